// File: doc/BRIEF.md
# Read-Address Sequence Command Detector

This block watches the control and address lines of an asynchronous-SRAM-style bus, which are sampled on the system clock. It looks for a fixed run of six read accesses to chosen addresses. The reads themselves return ordinary array data. When the first five addresses arrive in order, the sixth address chooses the command. One value issues a one-cycle request to copy the array into nonvolatile storage (store). A second value issues a one-cycle request to copy it back (recall).

When either request fires, the block raises a lockout. While the lockout is high the bus is cut off from the array: read data drivers are disabled and every access is ignored. The lockout drops when the nonvolatile sequencer signals completion. Whenever the sequencer reports that it is busy, the step counter is held at its start, whatever started the operation.

An access is counted once, on the clock where chip enable is first seen low. Any write aborts a partial run. Any read to an address that is not the expected next one also aborts it.

Top module: `nv_cmd_seq_detect`

## Requirements
- R1: After reset, store_req, recall_req and lockout are all 0.
- R2: Reads (ce_n falling with we_n=1) to 13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, then 13'h0F0F produce store_req=1 for exactly one clock, in the cycle after the sixth access is sampled. recall_req stays 0.
- R3: The same five leading reads followed by 13'h0F0E produce a one-clock recall_req and no store_req.
- R4: A read whose address is not the expected next one returns the detector to the start. The remaining steps of the broken run then produce no request.
- R5: Any clock with ce_n=0 and we_n=0 (a write) returns the detector to the start. This holds even when the write occurs inside an access that began as a read.
- R6: oe_n has no effect on detection.
- R7: A read of 13'h0000 that breaks a run counts as the first step of a new run.
- R8: lockout rises together with a request and stays high until nv_done is seen. While it is high, no access advances the detector and no request fires.
- R9: While nv_busy is 1, the detector is held at its start. Steps taken before the busy period do not count toward a later run.
- R10: A single access (one continuous ce_n low period) counts only once, even if the address changes while ce_n stays low.
- R11: dq_drive_en is 1 only when ce_n=0, we_n=1, oe_n=0 and lockout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Bus address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| nv_busy | input | 1 | Nonvolatile sequencer busy |
| nv_done | input | 1 | One-cycle completion pulse from the sequencer |
| store_req | output | 1 | One-cycle store command |
| recall_req | output | 1 | One-cycle recall command |
| lockout | output | 1 | Bus cut off from the array |
| dq_drive_en | output | 1 | Read data drivers enabled |

## Verification
The hardest state to reach is the sixth step. Purely random addresses almost never walk five keys in order, so the random stimulus picks the expected next key most of the time. It mixes in key-0 reads, stray addresses, writes and both final keys, and a bench model follows the step count to predict each request. Directed cases cover the rarer situations:
- a write that starts inside a read access;
- an address changed while ce_n is held low;
- a busy period in the middle of a run;
- reads attempted during the lockout window.

// File: rtl/nv_cmd_seq_detect.sv
module nv_cmd_seq_detect #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] KEY0       = 13'h0000,
  parameter logic [ADDR_W-1:0] KEY1       = 13'h1555,
  parameter logic [ADDR_W-1:0] KEY2       = 13'h0AAA,
  parameter logic [ADDR_W-1:0] KEY3       = 13'h1FFF,
  parameter logic [ADDR_W-1:0] KEY4       = 13'h10F0,
  parameter logic [ADDR_W-1:0] STORE_KEY  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_KEY = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              nv_busy,
  input  logic              nv_done,
  output logic              store_req,
  output logic              recall_req,
  output logic              lockout,
  output logic              dq_drive_en
);

  localparam int LEAD   = 5;
  localparam int STEP_W = $clog2(LEAD + 1);
  localparam logic [STEP_W-1:0] FINAL = STEP_W'(LEAD);

  logic              ce_q;
  logic              lock_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic [ADDR_W-1:0] want;

  always_comb begin
    unique case (step_q)
      STEP_W'(0): want = KEY0;
      STEP_W'(1): want = KEY1;
      STEP_W'(2): want = KEY2;
      STEP_W'(3): want = KEY3;
      default:    want = KEY4;
    endcase
  end

  wire rd_start = ce_q & ~ce_n & we_n & ~lock_q & ~nv_busy;
  wire wr_seen  = ~ce_n & ~we_n;
  wire at_final = (step_q == FINAL);
  wire hit      = ~at_final & (addr == want);
  wire fire_st  = rd_start & at_final & (addr == STORE_KEY);
  wire fire_rc  = rd_start & at_final & (addr == RECALL_KEY);

  always_comb begin
    step_d = step_q;
    if (lock_q || nv_busy || wr_seen)
      step_d = '0;
    else if (rd_start) begin
      if (hit)
        step_d = step_q + STEP_W'(1);
      else if (addr == KEY0)
        step_d = STEP_W'(1);
      else
        step_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q       <= 1'b1;
      lock_q     <= 1'b0;
      step_q     <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      ce_q       <= ce_n;
      step_q     <= step_d;
      store_req  <= fire_st;
      recall_req <= fire_rc;
      if (nv_done)
        lock_q <= 1'b0;
      else if (fire_st || fire_rc)
        lock_q <= 1'b1;
    end
  end

  assign lockout     = lock_q;
  assign dq_drive_en = ~ce_n & we_n & ~oe_n & ~lock_q;

endmodule

// File: rtl/nv_cmd_seq_detect_chk.sv
module nv_cmd_seq_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic nv_busy,
  input logic nv_done,
  input logic store_req,
  input logic recall_req,
  input logic lockout,
  input logic dq_drive_en
);

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) store_req |=> !store_req); // R2
  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) recall_req |=> !recall_req); // R3
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(store_req && recall_req)); // R3
  AST_REQ_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) (store_req || recall_req) |-> $past(!ce_n && we_n)); // R5
  AST_LOCK_RISE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(lockout) |-> (store_req || recall_req)); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (lockout && !nv_done) |=> lockout); // R8
  AST_NO_REQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) lockout |=> !(store_req || recall_req)); // R8
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) nv_busy |=> !(store_req || recall_req)); // R9
  AST_HIZ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) lockout |-> !dq_drive_en); // R11

endmodule

bind nv_cmd_seq_detect nv_cmd_seq_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .nv_busy(nv_busy),
  .nv_done(nv_done), .store_req(store_req), .recall_req(recall_req),
  .lockout(lockout), .dq_drive_en(dq_drive_en)
);

// File: tb/tb_nv_cmd_seq_detect.sv
module tb_nv_cmd_seq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, nv_busy = 1'b0, nv_done = 1'b0;
  logic store_req, recall_req, lockout, dq_drive_en;

  int n_chk = 0, n_bad = 0;
  int m_step = 0;
  bit m_lock = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nv_cmd_seq_detect dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .nv_busy(nv_busy), .nv_done(nv_done), .store_req(store_req),
    .recall_req(recall_req), .lockout(lockout), .dq_drive_en(dq_drive_en)
  );

  function automatic logic [12:0] key_of(int s);
    case (s)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  // returns trigger code: 0 none, 1 store, 2 recall; updates step
  function automatic int model_read(ref int s, input logic [12:0] a);
    int trig = 0;
    if (s == 5) begin
      if (a == 13'h0F0F) trig = 1;
      else if (a == 13'h0F0E) trig = 2;
      s = (trig != 0) ? 0 : (a == 13'h0000 ? 1 : 0);
    end else if (a == key_of(s)) s = s + 1;
    else s = (a == 13'h0000) ? 1 : 0;
    return trig;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sequencer_cycle();
    check("R8 lockout high", lockout, 1);
    nv_busy = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      addr = key_of(i % 5); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
      #0.1;
      check("R11 drivers off while locked", dq_drive_en, 0);
      @(negedge clk);
      check("R8 no request while locked", int'(store_req | recall_req), 0);
      check("R8 lockout held", lockout, 1);
      ce_n = 1'b1;
    end
    @(negedge clk); nv_busy = 1'b0; nv_done = 1'b1;
    @(negedge clk); nv_done = 1'b0;
    check("R8 lockout released", lockout, 0);
    m_lock = 1'b0; m_step = 0;
  endtask

  task automatic do_read(logic [12:0] a, logic oe, string req);
    int trig;
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = oe;
    #0.1;
    check("R11 drive enable", dq_drive_en, int'(!oe && !m_lock));
    trig = m_lock ? 0 : model_read(m_step, a);
    @(negedge clk);
    check({req, " store_req"}, store_req, int'(trig == 1));
    check({req, " recall_req"}, recall_req, int'(trig == 2));
    ce_n = 1'b1;
    @(negedge clk);
    check("R2 request one cycle", int'(store_req | recall_req), 0);
    if (trig != 0) begin
      m_lock = 1'b1;
      sequencer_cycle();
    end
  endtask

  task automatic do_write(logic [12:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    if (!m_lock) m_step = 0;
  endtask

  task automatic lead5();
    for (int i = 0; i < 5; i++) do_read(key_of(i), 1'b1, "lead");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 store_req reset", store_req, 0);
    check("R1 recall_req reset", recall_req, 0);
    check("R1 lockout reset", lockout, 0);
    rst_n = 1'b1;

    lead5(); do_read(13'h0F0F, 1'b1, "R2");
    lead5(); do_read(13'h0F0E, 1'b0, "R3");
    for (int i = 0; i < 5; i++) do_read(key_of(i), i[0], "R6");
    do_read(13'h0F0F, 1'b0, "R6");

    do_read(13'h0000, 1'b1, "R4"); do_read(13'h1555, 1'b1, "R4");
    do_read(13'h0123, 1'b1, "R4");
    for (int i = 2; i < 5; i++) do_read(key_of(i), 1'b1, "R4");
    do_read(13'h0F0F, 1'b1, "R4 broken run");

    for (int i = 0; i < 4; i++) do_read(key_of(i), 1'b1, "R5");
    do_write(13'h10F0);
    do_read(13'h10F0, 1'b1, "R5"); do_read(13'h0F0F, 1'b1, "R5 after write");

    for (int i = 0; i < 3; i++) do_read(key_of(i), 1'b1, "R5");
    @(negedge clk); addr = 13'h1FFF; ce_n = 1'b0; we_n = 1'b1;
    void'(model_read(m_step, 13'h1FFF));
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; m_step = 0;
    do_read(13'h10F0, 1'b1, "R5"); do_read(13'h0F0E, 1'b1, "R5 write inside read");

    for (int i = 0; i < 3; i++) do_read(key_of(i), 1'b1, "R7");
    do_read(13'h0000, 1'b1, "R7");
    for (int i = 1; i < 5; i++) do_read(key_of(i), 1'b1, "R7");
    do_read(13'h0F0F, 1'b1, "R7 restart counts");

    for (int i = 0; i < 3; i++) do_read(key_of(i), 1'b1, "R9");
    @(negedge clk); nv_busy = 1'b1;
    @(negedge clk); check("R9 busy alone no lockout", lockout, 0);
    nv_busy = 1'b0; m_step = 0;
    do_read(13'h1FFF, 1'b1, "R9"); do_read(13'h10F0, 1'b1, "R9");
    do_read(13'h0F0F, 1'b1, "R9 after busy");

    @(negedge clk); addr = 13'h0000; ce_n = 1'b0; we_n = 1'b1;
    void'(model_read(m_step, 13'h0000));
    @(negedge clk); addr = 13'h1555;
    @(negedge clk); addr = 13'h0AAA;
    @(negedge clk); ce_n = 1'b1;
    do_read(13'h1FFF, 1'b1, "R10"); do_read(13'h10F0, 1'b1, "R10");
    do_read(13'h0F0F, 1'b1, "R10 single count");

    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(99);
      logic [12:0] a;
      if (r < 8) do_write(13'($urandom));
      else begin
        if (r < 70) a = (m_step == 5) ? 13'h0F0F : key_of(m_step);
        else if (r < 78) a = 13'h0000;
        else if (r < 86) a = 13'h0F0E;
        else if (r < 90) a = 13'h0F0F;
        else a = 13'($urandom);
        do_read(a, 1'($urandom), "R4 random");
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule